// File: doc/BRIEF.md
# Configurable Register Field

This block holds one field of a control/status register. It is shared between the software bus and the hardware it controls. Software sees a register select, separate write-valid and read-valid handshakes, a write data bus and one enable per byte of that bus. Hardware sees a load value, an optional load enable of either polarity, the stored value on a continuous output, and optional AND, OR and XOR reductions of that value.

Parameters choose the behaviour of the field:
- how a software write changes the stored value (plain, set, clear or toggle on ones or zeros, or force to all zeros or all ones);
- whether a software read has a side-effect;
- whether hardware or software wins a same-cycle collision;
- whether an external signal gates software writes;
- whether the field clears itself one cycle after an update;
- how reset is applied.

A register map instantiates one copy per field. It places the field at a bit offset within the bus word.

Top module: `reg_field`

## Requirements
- R1: Reset loads RESET_VAL. With ASYNC_RST=1 the load happens without waiting for a clock edge. With ASYNC_RST=0 it happens at the first rising edge that sees reset active. RST_ACT_LOW selects the active level of `rst_in`.
- R2: The write strobe is `reg_sel & wr_valid` and the read strobe is `reg_sel & rd_valid`. When there is no accepted write, no read side-effect, no hardware load and no single-pulse clearing, the field holds its value.
- R3: Field bit i sits at bus bit FIELD_LSB+i and belongs to byte lane `wr_be[(FIELD_LSB+i)/8]`. A plain write replaces only the bits in enabled lanes. Lanes that lie outside the field have no effect.
- R4: In set-on-one mode (code 1), each enabled bit becomes current OR data. In clear-on-one mode (code 2), it becomes current AND NOT data.
- R5: The remaining per-lane modes work on enabled bits only:
  - toggle-on-one (code 3): current XOR data;
  - clear-on-zero (code 4): current AND data;
  - toggle-on-zero (code 5): current XNOR data.
- R6: In force-clear mode (code 6), any accepted write makes the whole field zero. In force-set mode (code 7), it makes the whole field all ones. Data and lane enables are ignored in both modes.
- R7: With the clear read effect, a read strobe makes the field zero. With the set read effect, it makes the field all ones. A write accepted in the same cycle takes priority over the read effect.
- R8: A hardware load stores `hw_data`. The load is qualified by `hw_wen` when it is active high, by `!hw_wen` when it is active low, and happens every cycle when no enable is configured.
- R9: When write gating is active high, a software write is accepted only when `sw_gate` is 1. When it is active low, a write is accepted only when `sw_gate` is 0.
- R10: When a software update and a hardware load coincide, HW_WINS selects which one is stored. The other update is discarded.
- R11: `fld_q` shows the stored value continuously. With RED_EN=1, `fld_and`, `fld_or` and `fld_xor` are the AND, OR and XOR reductions of that value.
- R12: With PULSE=1, a value written to the field is visible for one cycle. The field returns to zero on the next cycle unless it is updated again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_in | input | 1 | Reset, polarity set by RST_ACT_LOW |
| reg_sel | input | 1 | Address match for the register that holds this field |
| wr_valid | input | 1 | Bus write handshake |
| rd_valid | input | 1 | Bus read handshake |
| wr_data | input | BUS_W | Bus write data |
| wr_be | input | BUS_W/8 | Byte enables of the bus write |
| sw_gate | input | 1 | External gate for software writes |
| hw_data | input | WIDTH | Hardware load value |
| hw_wen | input | 1 | Hardware load enable |
| fld_q | output | WIDTH | Stored field value |
| fld_and | output | 1 | AND reduction of the field |
| fld_or | output | 1 | OR reduction of the field |
| fld_xor | output | 1 | XOR reduction of the field |

## Verification
The bound checker watches every cycle for these behaviours:
- holding when nothing is accepted;
- the force-clear and force-set results;
- the read-clear effect;
- hardware precedence;
- the single-pulse decay.

The bench's scenarios cover what only chosen data can reveal:
- the per-lane arithmetic of each write mode on full and partial lane sets;
- lane slicing from the middle of the bus word;
- the gate and enable polarities;
- the write-over-read priority;
- the difference between asynchronous and synchronous reset when reset is asserted mid-cycle.

// File: rtl/reg_field_pkg.sv
package reg_field_pkg;

  // Software write modifier. The code value is the mode number used in the requirements.
  typedef enum logic [2:0] {
    SWM_PLAIN  = 3'd0,
    SWM_SET1   = 3'd1,
    SWM_CLR1   = 3'd2,
    SWM_TGL1   = 3'd3,
    SWM_CLR0   = 3'd4,
    SWM_TGL0   = 3'd5,
    SWM_CLRALL = 3'd6,
    SWM_SETALL = 3'd7
  } sw_mod_e;

  // Side-effect of a software read.
  typedef enum logic [1:0] {
    RDE_NONE  = 2'd0,
    RDE_CLEAR = 2'd1,
    RDE_SET   = 2'd2
  } rd_eff_e;

  // Qualification of an enable input.
  typedef enum logic [1:0] {
    QUAL_NONE = 2'd0,
    QUAL_HIGH = 2'd1,
    QUAL_LOW  = 2'd2
  } qual_e;

  function automatic logic qual_pass(qual_e mode, logic en);
    case (mode)
      QUAL_HIGH: return en;
      QUAL_LOW:  return !en;
      default:   return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/field_strobe.sv
module field_strobe
  import reg_field_pkg::*;
#(
  parameter qual_e GATE_QUAL = QUAL_NONE
) (
  input  logic reg_sel,
  input  logic wr_valid,
  input  logic rd_valid,
  input  logic sw_gate,
  output logic wr_go,
  output logic rd_go
);

  logic gate_ok;
  logic unused_gate;

  assign gate_ok     = qual_pass(GATE_QUAL, sw_gate);
  assign wr_go       = reg_sel & wr_valid & gate_ok;
  assign rd_go       = reg_sel & rd_valid;
  assign unused_gate = sw_gate;

endmodule

// File: rtl/field_sw_update.sv
module field_sw_update
  import reg_field_pkg::*;
#(
  parameter int unsigned WIDTH     = 16,
  parameter int unsigned BUS_W     = 32,
  parameter int unsigned FIELD_LSB = 8,
  parameter sw_mod_e     SW_MODE   = SWM_PLAIN,
  parameter rd_eff_e     RD_MODE   = RDE_NONE
) (
  input  logic [WIDTH-1:0]   cur,
  input  logic [BUS_W-1:0]   wr_data,
  input  logic [BUS_W/8-1:0] wr_be,
  input  logic               wr_go,
  input  logic               rd_go,
  output logic               sw_act,
  output logic [WIDTH-1:0]   sw_val
);

  logic [WIDTH-1:0] lane_on;
  logic [WIDTH-1:0] wd;
  logic [WIDTH-1:0] mod_val;
  logic             unused_bits;

  // Per-bit lane enable and data slice taken from the bit's own bus position.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign lane_on[i] = wr_be[(FIELD_LSB + i) / 8];
    assign wd[i]      = wr_data[FIELD_LSB + i];
  end

  if (SW_MODE == SWM_SET1) begin : g_set1
    assign mod_val = cur | (lane_on & wd);
  end else if (SW_MODE == SWM_CLR1) begin : g_clr1
    assign mod_val = cur & ~(lane_on & wd);
  end else if (SW_MODE == SWM_TGL1) begin : g_tgl1
    assign mod_val = cur ^ (lane_on & wd);
  end else if (SW_MODE == SWM_CLR0) begin : g_clr0
    assign mod_val = cur & (~lane_on | wd);
  end else if (SW_MODE == SWM_TGL0) begin : g_tgl0
    assign mod_val = cur ^ (lane_on & ~wd);
  end else if (SW_MODE == SWM_CLRALL) begin : g_clrall
    assign mod_val = '0;
  end else if (SW_MODE == SWM_SETALL) begin : g_setall
    assign mod_val = {WIDTH{1'b1}};
  end else begin : g_plain
    assign mod_val = (lane_on & wd) | (~lane_on & cur);
  end

  // An accepted write outranks the read side-effect.
  always_comb begin
    sw_act = wr_go | (rd_go & (RD_MODE != RDE_NONE));
    if (wr_go) begin
      sw_val = mod_val;
    end else if (RD_MODE == RDE_SET) begin
      sw_val = {WIDTH{1'b1}};
    end else begin
      sw_val = '0;
    end
  end

  assign unused_bits = ^{wr_data, wr_be, lane_on, wd};

endmodule

// File: rtl/field_reduce.sv
module field_reduce #(
  parameter int unsigned WIDTH  = 16,
  parameter bit          RED_EN = 1'b1
) (
  input  logic [WIDTH-1:0] val,
  output logic             red_and,
  output logic             red_or,
  output logic             red_xor
);

  logic unused_val;

  if (RED_EN) begin : g_red
    assign red_and = &val;
    assign red_or  = |val;
    assign red_xor = ^val;
  end else begin : g_nored
    assign red_and = 1'b0;
    assign red_or  = 1'b0;
    assign red_xor = 1'b0;
  end

  assign unused_val = ^val;

endmodule

// File: rtl/reg_field.sv
module reg_field
  import reg_field_pkg::*;
#(
  parameter int unsigned      WIDTH       = 16,
  parameter int unsigned      BUS_W       = 32,
  parameter int unsigned      FIELD_LSB   = 8,
  parameter logic [WIDTH-1:0] RESET_VAL   = '0,
  parameter sw_mod_e          SW_MODE     = SWM_PLAIN,
  parameter rd_eff_e          RD_MODE     = RDE_NONE,
  parameter qual_e            HW_WE_QUAL  = QUAL_HIGH,
  parameter qual_e            GATE_QUAL   = QUAL_NONE,
  parameter bit               HW_WINS     = 1'b0,
  parameter bit               PULSE       = 1'b0,
  parameter bit               RED_EN      = 1'b1,
  parameter bit               ASYNC_RST   = 1'b1,
  parameter bit               RST_ACT_LOW = 1'b1
) (
  input  logic               clk,
  input  logic               rst_in,
  input  logic               reg_sel,
  input  logic               wr_valid,
  input  logic               rd_valid,
  input  logic [BUS_W-1:0]   wr_data,
  input  logic [BUS_W/8-1:0] wr_be,
  input  logic               sw_gate,
  input  logic [WIDTH-1:0]   hw_data,
  input  logic               hw_wen,
  output logic [WIDTH-1:0]   fld_q,
  output logic               fld_and,
  output logic               fld_or,
  output logic               fld_xor
);

  logic             wr_go;
  logic             rd_go;
  logic             sw_act;
  logic [WIDTH-1:0] sw_val;
  logic             hw_ld;
  logic [WIDTH-1:0] fld_r;
  logic [WIDTH-1:0] fld_nxt;
  logic             fld_en;
  logic             unused_wen;

  field_strobe #(
    .GATE_QUAL (GATE_QUAL)
  ) u_strobe (
    .reg_sel  (reg_sel),
    .wr_valid (wr_valid),
    .rd_valid (rd_valid),
    .sw_gate  (sw_gate),
    .wr_go    (wr_go),
    .rd_go    (rd_go)
  );

  field_sw_update #(
    .WIDTH     (WIDTH),
    .BUS_W     (BUS_W),
    .FIELD_LSB (FIELD_LSB),
    .SW_MODE   (SW_MODE),
    .RD_MODE   (RD_MODE)
  ) u_sw (
    .cur     (fld_r),
    .wr_data (wr_data),
    .wr_be   (wr_be),
    .wr_go   (wr_go),
    .rd_go   (rd_go),
    .sw_act  (sw_act),
    .sw_val  (sw_val)
  );

  assign hw_ld      = qual_pass(HW_WE_QUAL, hw_wen);
  assign unused_wen = hw_wen;

  // Next-state selection with configurable precedence.
  always_comb begin
    fld_nxt = PULSE ? '0 : fld_r;
    if (HW_WINS) begin
      if (hw_ld) begin
        fld_nxt = hw_data;
      end else if (sw_act) begin
        fld_nxt = sw_val;
      end
    end else begin
      if (sw_act) begin
        fld_nxt = sw_val;
      end else if (hw_ld) begin
        fld_nxt = hw_data;
      end
    end
    fld_en = sw_act | hw_ld | (PULSE & (|fld_r));
  end

  // Storage register, reset style chosen by parameters.
  if (ASYNC_RST && RST_ACT_LOW) begin : g_arst_lo
    always_ff @(posedge clk or negedge rst_in) begin
      if (!rst_in) begin
        fld_r <= RESET_VAL;
      end else if (fld_en) begin
        fld_r <= fld_nxt;
      end
    end
  end else if (ASYNC_RST) begin : g_arst_hi
    always_ff @(posedge clk or posedge rst_in) begin
      if (rst_in) begin
        fld_r <= RESET_VAL;
      end else if (fld_en) begin
        fld_r <= fld_nxt;
      end
    end
  end else begin : g_srst
    logic rst_hit;
    assign rst_hit = RST_ACT_LOW ? !rst_in : rst_in;
    always_ff @(posedge clk) begin
      if (rst_hit) begin
        fld_r <= RESET_VAL;
      end else if (fld_en) begin
        fld_r <= fld_nxt;
      end
    end
  end

  assign fld_q = fld_r;

  field_reduce #(
    .WIDTH  (WIDTH),
    .RED_EN (RED_EN)
  ) u_red (
    .val     (fld_r),
    .red_and (fld_and),
    .red_or  (fld_or),
    .red_xor (fld_xor)
  );

endmodule

// File: rtl/reg_field_chk.sv
module reg_field_chk
  import reg_field_pkg::*;
#(
  parameter int unsigned WIDTH       = 16,
  parameter sw_mod_e     SW_MODE     = SWM_PLAIN,
  parameter rd_eff_e     RD_MODE     = RDE_NONE,
  parameter qual_e       HW_WE_QUAL  = QUAL_HIGH,
  parameter qual_e       GATE_QUAL   = QUAL_NONE,
  parameter bit          HW_WINS     = 1'b0,
  parameter bit          PULSE       = 1'b0,
  parameter bit          RST_ACT_LOW = 1'b1
) (
  input logic             clk,
  input logic             rst_in,
  input logic             reg_sel,
  input logic             wr_valid,
  input logic             rd_valid,
  input logic             sw_gate,
  input logic [WIDTH-1:0] hw_data,
  input logic             hw_wen,
  input logic [WIDTH-1:0] fld_q
);

  logic rst_on;
  logic wr_ok;
  logic rd_hit;
  logic rd_fx;
  logic hw_hit;

  assign rst_on = RST_ACT_LOW ? !rst_in : rst_in;
  assign wr_ok  = reg_sel && wr_valid && qual_pass(GATE_QUAL, sw_gate);
  assign rd_hit = reg_sel && rd_valid;
  assign rd_fx  = rd_hit && (RD_MODE != RDE_NONE);
  assign hw_hit = qual_pass(HW_WE_QUAL, hw_wen);

  // R2: nothing accepted, the field holds
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst_on)
    (!wr_ok && !rd_fx && !hw_hit && !PULSE) |=> $stable(fld_q));

  // R10: hardware precedence keeps the hardware value
  a_r10_hw_wins: assert property (@(posedge clk) disable iff (rst_on)
    (HW_WINS && hw_hit) |=> (fld_q == $past(hw_data)));

  // R6: force-clear ignores data and lanes
  a_r6_force_clear: assert property (@(posedge clk) disable iff (rst_on)
    ((SW_MODE == SWM_CLRALL) && wr_ok && (!HW_WINS || !hw_hit)) |=> (fld_q == '0));

  // R6: force-set ignores data and lanes
  a_r6_force_set: assert property (@(posedge clk) disable iff (rst_on)
    ((SW_MODE == SWM_SETALL) && wr_ok && (!HW_WINS || !hw_hit)) |=> (&fld_q));

  // R7: read-clear effect when no write coincides
  a_r7_read_clear: assert property (@(posedge clk) disable iff (rst_on)
    ((RD_MODE == RDE_CLEAR) && rd_hit && !wr_ok && (!HW_WINS || !hw_hit)) |=> (fld_q == '0));

  // R12: single-pulse field decays to zero without a new update
  a_r12_pulse_decay: assert property (@(posedge clk) disable iff (rst_on)
    (PULSE && !wr_ok && !rd_fx && !hw_hit) |=> (fld_q == '0));

endmodule

bind reg_field reg_field_chk #(
  .WIDTH       (WIDTH),
  .SW_MODE     (SW_MODE),
  .RD_MODE     (RD_MODE),
  .HW_WE_QUAL  (HW_WE_QUAL),
  .GATE_QUAL   (GATE_QUAL),
  .HW_WINS     (HW_WINS),
  .PULSE       (PULSE),
  .RST_ACT_LOW (RST_ACT_LOW)
) u_chk (
  .clk      (clk),
  .rst_in   (rst_in),
  .reg_sel  (reg_sel),
  .wr_valid (wr_valid),
  .rd_valid (rd_valid),
  .sw_gate  (sw_gate),
  .hw_data  (hw_data),
  .hw_wen   (hw_wen),
  .fld_q    (fld_q)
);

// File: tb/tb_reg_field.sv
module tb_reg_field;
  import reg_field_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] RV = 16'hA5C3;

  logic        clk;
  logic        rst_n;
  logic        rst_hi;
  logic        sel;
  logic        wr_vld;
  logic        rd_vld;
  logic [31:0] wdata;
  logic [3:0]  be;
  logic        gate_hi;
  logic        gate_lo;
  logic [15:0] hw_d;
  logic        hw_we;
  logic        hw_we_n;

  logic [15:0] q_dut, q_alt, q_free, q_pulse;
  logic        and_dut, or_dut, xor_dut;
  logic        and_alt, or_alt, xor_alt;
  logic        and_free, or_free, xor_free;
  logic        and_pulse, or_pulse, xor_pulse;
  logic [15:0] q_m [8];
  logic        and_m [8];
  logic        or_m [8];
  logic        xor_m [8];

  int n_chk;
  int n_fail;

  // Expected results per mode code, current 16'h3C5A.
  // Full lanes use data 16'h0FF0; low lane only uses data 16'hFFFF.
  logic [15:0] exp_full [8] = '{16'h0FF0, 16'h3FFA, 16'h300A, 16'h33AA,
                                16'h0C50, 16'hCC55, 16'h0000, 16'hFFFF};
  logic [15:0] exp_part [8] = '{16'h3CFF, 16'h3CFF, 16'h3C00, 16'h3CA5,
                                16'h3C5A, 16'h3C5A, 16'h0000, 16'hFFFF};

  assign rst_hi = ~rst_n;

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // Main instance: plain write, read-clear, active-high hw enable, software wins.
  reg_field #(
    .RESET_VAL (RV), .SW_MODE (SWM_PLAIN), .RD_MODE (RDE_CLEAR),
    .HW_WE_QUAL (QUAL_HIGH), .GATE_QUAL (QUAL_NONE), .HW_WINS (1'b0)
  ) dut (
    .clk (clk), .rst_in (rst_n), .reg_sel (sel), .wr_valid (wr_vld), .rd_valid (rd_vld),
    .wr_data (wdata), .wr_be (be), .sw_gate (gate_hi), .hw_data (hw_d), .hw_wen (hw_we),
    .fld_q (q_dut), .fld_and (and_dut), .fld_or (or_dut), .fld_xor (xor_dut)
  );

  // One instance per write modifier.
  for (genvar m = 0; m < 8; m++) begin : g_mode
    reg_field #(
      .RESET_VAL (RV), .SW_MODE (sw_mod_e'(m)), .RD_MODE (RDE_NONE),
      .HW_WE_QUAL (QUAL_HIGH)
    ) u_mode (
      .clk (clk), .rst_in (rst_n), .reg_sel (sel), .wr_valid (wr_vld), .rd_valid (rd_vld),
      .wr_data (wdata), .wr_be (be), .sw_gate (gate_hi), .hw_data (hw_d), .hw_wen (hw_we),
      .fld_q (q_m[m]), .fld_and (and_m[m]), .fld_or (or_m[m]), .fld_xor (xor_m[m])
    );
  end

  // Hardware wins, active-low hw enable, active-high gate, read-set, sync active-high reset.
  reg_field #(
    .RESET_VAL (RV), .SW_MODE (SWM_PLAIN), .RD_MODE (RDE_SET),
    .HW_WE_QUAL (QUAL_LOW), .GATE_QUAL (QUAL_HIGH), .HW_WINS (1'b1),
    .ASYNC_RST (1'b0), .RST_ACT_LOW (1'b0)
  ) u_alt (
    .clk (clk), .rst_in (rst_hi), .reg_sel (sel), .wr_valid (wr_vld), .rd_valid (rd_vld),
    .wr_data (wdata), .wr_be (be), .sw_gate (gate_hi), .hw_data (hw_d), .hw_wen (hw_we_n),
    .fld_q (q_alt), .fld_and (and_alt), .fld_or (or_alt), .fld_xor (xor_alt)
  );

  // Hardware loads every cycle, active-low gate, software wins.
  reg_field #(
    .RESET_VAL (RV), .SW_MODE (SWM_PLAIN), .RD_MODE (RDE_NONE),
    .HW_WE_QUAL (QUAL_NONE), .GATE_QUAL (QUAL_LOW), .HW_WINS (1'b0)
  ) u_free (
    .clk (clk), .rst_in (rst_n), .reg_sel (sel), .wr_valid (wr_vld), .rd_valid (rd_vld),
    .wr_data (wdata), .wr_be (be), .sw_gate (gate_lo), .hw_data (hw_d), .hw_wen (hw_we),
    .fld_q (q_free), .fld_and (and_free), .fld_or (or_free), .fld_xor (xor_free)
  );

  // Single-pulse field.
  reg_field #(
    .RESET_VAL (16'h0000), .SW_MODE (SWM_PLAIN), .RD_MODE (RDE_NONE),
    .HW_WE_QUAL (QUAL_HIGH), .PULSE (1'b1)
  ) u_pulse (
    .clk (clk), .rst_in (rst_n), .reg_sel (sel), .wr_valid (wr_vld), .rd_valid (rd_vld),
    .wr_data (wdata), .wr_be (be), .sw_gate (gate_hi), .hw_data (hw_d), .hw_wen (hw_we),
    .fld_q (q_pulse), .fld_and (and_pulse), .fld_or (or_pulse), .fld_xor (xor_pulse)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Software write of a 16-bit field value; returns one cycle later at a falling edge.
  task automatic sw_write(input logic [15:0] d, input logic [3:0] lanes);
    sel = 1'b1; wr_vld = 1'b1; wdata = {8'h00, d, 8'h00}; be = lanes;
    @(negedge clk);
    sel = 1'b0; wr_vld = 1'b0; wdata = '0; be = '0;
  endtask

  task automatic hw_load(input logic [15:0] d);
    hw_we = 1'b1; hw_d = d;
    @(negedge clk);
    hw_we = 1'b0;
  endtask

  task automatic sw_read();
    sel = 1'b1; rd_vld = 1'b1;
    @(negedge clk);
    sel = 1'b0; rd_vld = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset dut", q_dut, RV);
    chk("R1 reset mode0", q_m[0], RV);
    chk("R1 reset sync", q_alt, RV);
    chk("R11 and after reset", {15'd0, and_dut}, 16'd0);
    chk("R11 or after reset", {15'd0, or_dut}, 16'd1);
    chk("R11 xor after reset", {15'd0, xor_dut}, 16'd0);
  endtask

  task automatic t_plain();
    sw_write(16'h1234, 4'b0110);
    chk("R3 full lanes", q_dut, 16'h1234);
    sw_write(16'h5678, 4'b0010);
    chk("R3 low lane only", q_dut, 16'h1278);
    sw_write(16'hABCD, 4'b1001);
    chk("R3 lanes outside field", q_dut, 16'h1278);
  endtask

  task automatic t_hold();
    sel = 1'b1; wr_vld = 1'b0; rd_vld = 1'b0; wdata = 32'hFFFF_FFFF; be = 4'hF;
    @(negedge clk);
    chk("R2 select without valid", q_dut, 16'h1278);
    sel = 1'b0; wr_vld = 1'b1; rd_vld = 1'b1;
    @(negedge clk);
    chk("R2 valid without select", q_dut, 16'h1278);
    wr_vld = 1'b0; rd_vld = 1'b0; wdata = '0; be = '0;
    @(negedge clk);
    chk("R2 idle", q_dut, 16'h1278);
  endtask

  task automatic t_modes();
    hw_load(16'h3C5A);
    chk("R8 hw load mode3", q_m[3], 16'h3C5A);
    sw_write(16'h0FF0, 4'b0110);
    for (int m = 0; m < 8; m++) begin
      chk($sformatf("R4 R5 R6 full lanes mode %0d", m), q_m[m], exp_full[m]);
    end
    hw_load(16'h3C5A);
    sw_write(16'hFFFF, 4'b0010);
    for (int m = 0; m < 8; m++) begin
      chk($sformatf("R4 R5 R6 partial lanes mode %0d", m), q_m[m], exp_part[m]);
    end
  endtask

  task automatic t_read();
    sw_read();
    chk("R7 read clear", q_dut, 16'h0000);
    chk("R7 read set", q_alt, 16'hFFFF);
    hw_load(16'h7777);
    sel = 1'b1; rd_vld = 1'b1; wr_vld = 1'b1; wdata = {8'h00, 16'h4321, 8'h00}; be = 4'b0110;
    @(negedge clk);
    sel = 1'b0; rd_vld = 1'b0; wr_vld = 1'b0; wdata = '0; be = '0;
    chk("R7 write over read", q_dut, 16'h4321);
  endtask

  task automatic t_hw();
    hw_we = 1'b0; hw_d = 16'h9999;
    @(negedge clk);
    chk("R8 enable low holds", q_dut, 16'h4321);
    hw_load(16'h9999);
    chk("R8 enable high loads", q_dut, 16'h9999);
    hw_we_n = 1'b0; hw_d = 16'h0246;
    @(negedge clk);
    chk("R8 active-low load", q_alt, 16'h0246);
    hw_we_n = 1'b1; hw_d = 16'h1111;
    @(negedge clk);
    chk("R8 active-low idle", q_alt, 16'h0246);
    hw_d = 16'h5A5A;
    @(negedge clk);
    chk("R8 load every cycle", q_free, 16'h5A5A);
  endtask

  task automatic t_prec();
    hw_we = 1'b1; hw_d = 16'hAAAA;
    sw_write(16'h5555, 4'b0110);
    hw_we = 1'b0;
    chk("R10 software wins", q_dut, 16'h5555);
    hw_we_n = 1'b0; gate_hi = 1'b1; hw_d = 16'hAAAA;
    sw_write(16'h5555, 4'b0110);
    hw_we_n = 1'b1; gate_hi = 1'b0;
    chk("R10 hardware wins", q_alt, 16'hAAAA);
  endtask

  task automatic t_gate();
    gate_hi = 1'b0;
    sw_write(16'h1357, 4'b0110);
    chk("R9 high gate closed", q_alt, 16'hAAAA);
    gate_hi = 1'b1;
    sw_write(16'h1357, 4'b0110);
    gate_hi = 1'b0;
    chk("R9 high gate open", q_alt, 16'h1357);
    hw_d = 16'h0F0F; gate_lo = 1'b1;
    sw_write(16'h2468, 4'b0110);
    chk("R9 low gate closed", q_free, 16'h0F0F);
    gate_lo = 1'b0;
    sw_write(16'h2468, 4'b0110);
    gate_lo = 1'b1;
    chk("R9 low gate open", q_free, 16'h2468);
  endtask

  task automatic t_red();
    hw_load(16'hFFFF);
    chk("R11 q out", q_dut, 16'hFFFF);
    chk("R11 and all ones", {15'd0, and_dut}, 16'd1);
    chk("R11 xor all ones", {15'd0, xor_dut}, 16'd0);
    hw_load(16'h0001);
    chk("R11 and one bit", {15'd0, and_dut}, 16'd0);
    chk("R11 xor one bit", {15'd0, xor_dut}, 16'd1);
    hw_load(16'h0000);
    chk("R11 or zero", {15'd0, or_dut}, 16'd0);
  endtask

  task automatic t_pulse();
    @(negedge clk);
    chk("R12 idle zero", q_pulse, 16'h0000);
    sw_write(16'h1234, 4'b0110);
    chk("R12 visible one cycle", q_pulse, 16'h1234);
    @(negedge clk);
    chk("R12 returns to zero", q_pulse, 16'h0000);
  endtask

  task automatic t_async();
    #2 rst_n = 1'b0;
    #1;
    chk("R1 async immediate", q_dut, RV);
    chk("R1 sync waits for edge", q_alt, 16'h1357);
    @(negedge clk);
    chk("R1 sync at edge", q_alt, RV);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; sel = 1'b0; wr_vld = 1'b0; rd_vld = 1'b0; wdata = '0; be = '0;
    gate_hi = 1'b0; gate_lo = 1'b1; hw_d = '0; hw_we = 1'b0; hw_we_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_hold();
    t_modes();
    t_read();
    t_hw();
    t_prec();
    t_gate();
    t_red();
    t_pulse();
    t_async();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule